// File: doc/BRIEF.md
# Condition Flag and Predication Unit

This block keeps the four arithmetic status flags (negative, zero, carry, overflow) of a 32-bit RISC datapath and decides, every cycle, whether the instruction now in the execute stage may take effect. It receives the ALU result, the adder carry-out, the adder overflow indication, a two-bit operation class, a set-flags request and a four-bit condition field. It evaluates the condition against the stored flags and drives an execute-enable output. When the rules permit, it loads new flag values at the next clock edge.

A fifth stored bit selects the byte order of data accesses: 1 selects big-endian and 0 selects little-endian. This bit is written only through its own write port, and flag updates never change it. The execute-enable output is combinational from the current flags and the condition field. Flag changes caused by an instruction become visible one cycle later.

Top module: `cond_flag_unit`

## Requirements
- R1: A synchronous active-high reset clears N, Z, C, V and the byte-order bit to 0. Reset takes priority over every other input.
- R2: On a flag update, Z becomes 1 exactly when the 32-bit result is zero, and N becomes bit 31 of the result.
- R3: On an arithmetic (class 2'b00) or compare (class 2'b10) update, C takes the carry-out input and V takes the overflow input.
- R4: On a logical (class 2'b01) update, N, Z and C are loaded but V keeps its previous value.
- R5: An arithmetic or logical operation with the set-flags request low leaves all four flags unchanged.
- R6: A compare (class 2'b10) whose condition passes updates the flags even when the set-flags request is low.
- R7: Execute-enable follows this table for the condition codes:
  - 0: Z
  - 1: !Z
  - 2: C
  - 3: !C
  - 4: N
  - 5: !N
  - 6: V
  - 7: !V
  - 8: C&!Z
  - 9: !C|Z
  - 10: N==V
  - 11: N!=V
  - 12: !Z&(N==V)
  - 13: Z|(N!=V)
  - 14 and 15: always 1
- R8: When the condition fails, execute-enable is 0 and no flag changes, even with the set-flags request high.
- R9: The condition is evaluated on the flags held before the current instruction. That instruction's own update is visible only from the next cycle.
- R10: The byte-order bit is loaded from its value input only in a cycle where its write strobe is high. Flag updates leave it unchanged.
- R11: Operation class 2'b11 never changes the flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| res_i | input | 32 | ALU result of the current instruction |
| carry_i | input | 1 | Carry out of bit 31 of the operation |
| ovf_i | input | 1 | Signed overflow from the adder |
| op_class_i | input | 2 | 00 arithmetic, 01 logical, 10 compare, 11 no-flag |
| setf_i | input | 1 | Set-flags request |
| cond_i | input | 4 | Condition field |
| e_wr_i | input | 1 | Byte-order bit write strobe |
| e_val_i | input | 1 | Byte-order bit value to write |
| exec_en_o | output | 1 | Current instruction may take effect |
| n_o | output | 1 | Stored negative flag |
| z_o | output | 1 | Stored zero flag |
| c_o | output | 1 | Stored carry flag |
| v_o | output | 1 | Stored overflow flag |
| e_o | output | 1 | Stored byte-order bit (1 = big-endian) |

## Verification
A corrupted flag register shows at the flag outputs one cycle after the faulty edge. In the same cycle, it also shows at execute-enable for any condition code that reads the bad flag. For this reason, the bench sweeps all sixteen codes over every reachable flag combination.

A wrong update gate has a different signature. Either a flag moves after a failed condition, a clear set-flags request or a no-flag class, or a compare fails to load. Each of these is visible on the next cycle's flag outputs. A gate that looks at post-update flags instead of stored ones shows as a wrong execute-enable in the updating cycle itself.

// File: rtl/cfu_pkg.sv
package cfu_pkg;

  typedef enum logic [1:0] {
    OPC_ARITH = 2'b00,
    OPC_LOGIC = 2'b01,
    OPC_CMP   = 2'b10,
    OPC_NONE  = 2'b11
  } opc_e;

  typedef enum logic [3:0] {
    CC_EQ = 4'h0, CC_NE = 4'h1, CC_CS = 4'h2, CC_CC = 4'h3,
    CC_MI = 4'h4, CC_PL = 4'h5, CC_VS = 4'h6, CC_VC = 4'h7,
    CC_HI = 4'h8, CC_LS = 4'h9, CC_GE = 4'hA, CC_LT = 4'hB,
    CC_GT = 4'hC, CC_LE = 4'hD, CC_AL = 4'hE, CC_NV = 4'hF
  } cc_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  // Condition predicate on a flag set.
  function automatic logic cc_holds(cc_e cc, nzcv_t f);
    logic r;
    case (cc)
      CC_EQ: r = f.z;
      CC_NE: r = !f.z;
      CC_CS: r = f.c;
      CC_CC: r = !f.c;
      CC_MI: r = f.n;
      CC_PL: r = !f.n;
      CC_VS: r = f.v;
      CC_VC: r = !f.v;
      CC_HI: r = f.c && !f.z;
      CC_LS: r = !f.c || f.z;
      CC_GE: r = (f.n == f.v);
      CC_LT: r = (f.n != f.v);
      CC_GT: r = !f.z && (f.n == f.v);
      CC_LE: r = f.z || (f.n != f.v);
      default: r = 1'b1;
    endcase
    return r;
  endfunction

  // Candidate flags from result properties; V kept when told to.
  function automatic nzcv_t derive_flags(logic sign, logic zero, logic cy,
                                         logic ov, logic keep_v, nzcv_t cur);
    nzcv_t t;
    t.n = sign;
    t.z = zero;
    t.c = cy;
    t.v = keep_v ? cur.v : ov;
    return t;
  endfunction

endpackage

// File: rtl/cfu_cond_eval.sv
module cfu_cond_eval
  import cfu_pkg::*;
(
  input  logic [3:0] cc_i,
  input  nzcv_t      flags_i,
  output logic       pass_o
);
  always_comb pass_o = cc_holds(cc_e'(cc_i), flags_i);
endmodule

// File: rtl/cfu_flag_calc.sv
module cfu_flag_calc
  import cfu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] res_i,
  input  logic         carry_i,
  input  logic         ovf_i,
  input  logic [1:0]   op_class_i,
  input  logic         setf_i,
  input  logic         pass_i,
  input  nzcv_t        cur_i,
  output nzcv_t        nxt_o,
  output logic         wr_o
);
  localparam int MSB = W - 1;

  opc_e opc;
  logic res_zero;
  logic wants_update;

  always_comb begin
    opc          = opc_e'(op_class_i);
    res_zero     = (res_i == '0);
    wants_update = (opc == OPC_CMP) ||
                   (setf_i && (opc == OPC_ARITH || opc == OPC_LOGIC));
    wr_o         = pass_i && wants_update;
    nxt_o        = derive_flags(res_i[MSB], res_zero, carry_i, ovf_i,
                                opc == OPC_LOGIC, cur_i);
  end
endmodule

// File: rtl/cfu_status_reg.sv
module cfu_status_reg
  import cfu_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  wr_i,
  input  nzcv_t nxt_i,
  input  logic  e_wr_i,
  input  logic  e_val_i,
  output nzcv_t flags_o,
  output logic  e_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flags_o <= '0;
      e_o     <= 1'b0;
    end else begin
      if (wr_i)   flags_o <= nxt_i;
      if (e_wr_i) e_o     <= e_val_i;
    end
  end
endmodule

// File: rtl/cond_flag_unit.sv
module cond_flag_unit
  import cfu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] res_i,
  input  logic         carry_i,
  input  logic         ovf_i,
  input  logic [1:0]   op_class_i,
  input  logic         setf_i,
  input  logic [3:0]   cond_i,
  input  logic         e_wr_i,
  input  logic         e_val_i,
  output logic         exec_en_o,
  output logic         n_o,
  output logic         z_o,
  output logic         c_o,
  output logic         v_o,
  output logic         e_o
);
  nzcv_t flags_q;
  nzcv_t flags_nxt;
  logic  cond_pass;
  logic  flag_wr;

  cfu_cond_eval u_eval (
    .cc_i    (cond_i),
    .flags_i (flags_q),
    .pass_o  (cond_pass)
  );

  cfu_flag_calc #(.W(W)) u_calc (
    .res_i      (res_i),
    .carry_i    (carry_i),
    .ovf_i      (ovf_i),
    .op_class_i (op_class_i),
    .setf_i     (setf_i),
    .pass_i     (cond_pass),
    .cur_i      (flags_q),
    .nxt_o      (flags_nxt),
    .wr_o       (flag_wr)
  );

  cfu_status_reg u_reg (
    .clk     (clk),
    .rst     (rst),
    .wr_i    (flag_wr),
    .nxt_i   (flags_nxt),
    .e_wr_i  (e_wr_i),
    .e_val_i (e_val_i),
    .flags_o (flags_q),
    .e_o     (e_o)
  );

  assign exec_en_o = cond_pass;
  assign n_o = flags_q.n;
  assign z_o = flags_q.z;
  assign c_o = flags_q.c;
  assign v_o = flags_q.v;
endmodule

// File: rtl/cfu_chk.sv
module cfu_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] res_i,
  input logic         carry_i,
  input logic [1:0]   op_class_i,
  input logic         setf_i,
  input logic [3:0]   cond_i,
  input logic         e_wr_i,
  input logic         exec_en_o,
  input logic         n_o,
  input logic         z_o,
  input logic         c_o,
  input logic         v_o,
  input logic         e_o,
  input logic         flag_wr
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> ({n_o, z_o, c_o, v_o, e_o} == 5'b0));

  // R2
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    flag_wr |=> (z_o == ($past(res_i) == '0)) && (n_o == $past(res_i[W-1])));

  // R4
  logic_keeps_v_chk: assert property (@(posedge clk) disable iff (rst)
    (op_class_i == 2'b01) |=> $stable(v_o));

  // R5
  no_setf_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!setf_i && op_class_i != 2'b10) |=> $stable({n_o, z_o, c_o, v_o}));

  // R6
  compare_load_chk: assert property (@(posedge clk) disable iff (rst)
    (op_class_i == 2'b10 && exec_en_o) |=> (c_o == $past(carry_i)));

  // R7
  always_cond_chk: assert property (@(posedge clk) disable iff (rst)
    (cond_i[3:1] == 3'b111) |-> exec_en_o);

  // R8
  cond_fail_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !exec_en_o |=> $stable({n_o, z_o, c_o, v_o}));

  // R10
  e_port_only_chk: assert property (@(posedge clk) disable iff (rst)
    !e_wr_i |=> $stable(e_o));

  // R11
  none_class_chk: assert property (@(posedge clk) disable iff (rst)
    (op_class_i == 2'b11) |=> $stable({n_o, z_o, c_o, v_o}));
endmodule

bind cond_flag_unit cfu_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .res_i      (res_i),
  .carry_i    (carry_i),
  .op_class_i (op_class_i),
  .setf_i     (setf_i),
  .cond_i     (cond_i),
  .e_wr_i     (e_wr_i),
  .exec_en_o  (exec_en_o),
  .n_o        (n_o),
  .z_o        (z_o),
  .c_o        (c_o),
  .v_o        (v_o),
  .e_o        (e_o),
  .flag_wr    (flag_wr)
);

// File: tb/test_cond_flag_unit.sv
`timescale 1ns/1ps
module test_cond_flag_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] res_i = '0;
  logic        carry_i = 1'b0, ovf_i = 1'b0, setf_i = 1'b0;
  logic [1:0]  op_class_i = 2'b00;
  logic [3:0]  cond_i = 4'hE;
  logic        e_wr_i = 1'b0, e_val_i = 1'b0;
  logic        exec_en_o, n_o, z_o, c_o, v_o, e_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cond_flag_unit i_cond_flag_unit (
    .clk(clk), .rst(rst), .res_i(res_i), .carry_i(carry_i), .ovf_i(ovf_i),
    .op_class_i(op_class_i), .setf_i(setf_i), .cond_i(cond_i),
    .e_wr_i(e_wr_i), .e_val_i(e_val_i), .exec_en_o(exec_en_o),
    .n_o(n_o), .z_o(z_o), .c_o(c_o), .v_o(v_o), .e_o(e_o)
  );

  typedef struct {
    string    tag;
    logic     exec;
    logic [4:0] post;   // {n,z,c,v,e}
  } item_t;
  item_t q[$];

  // reference state
  logic mn = 0, mz = 0, mc = 0, mv = 0, me = 0;

  function automatic logic ref_cond(logic [3:0] cc, logic n, logic z, logic c, logic v);
    logic r;
    case (cc[3:1])
      3'd0: r = z;
      3'd1: r = c;
      3'd2: r = n;
      3'd3: r = v;
      3'd4: r = c & ~z;
      3'd5: r = (n ~^ v);
      3'd6: r = ~z & (n ~^ v);
      default: r = 1'b1;
    endcase
    if (cc[3:1] != 3'd7 && cc[0]) r = ~r;
    return r;
  endfunction

  task automatic step(string tag, logic [3:0] cc, logic [1:0] cls, logic sf,
                      logic [31:0] res, logic cy, logic ov,
                      logic ewr = 1'b0, logic ev = 1'b0);
    item_t it;
    logic pass, upd;
    @(negedge clk);
    cond_i = cc; op_class_i = cls; setf_i = sf; res_i = res;
    carry_i = cy; ovf_i = ov; e_wr_i = ewr; e_val_i = ev;
    pass = ref_cond(cc, mn, mz, mc, mv);
    upd  = pass && (cls == 2'b10 || (sf && cls != 2'b11));
    if (upd) begin
      mn = res[31]; mz = (res == 0); mc = cy;
      if (cls != 2'b01) mv = ov;
    end
    if (ewr) me = ev;
    it.tag = tag; it.exec = pass; it.post = {mn, mz, mc, mv, me};
    q.push_back(it);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (q.size() > 0) begin
        item_t it;
        logic ex;
        it = q.pop_front();
        ex = exec_en_o;
        @(posedge clk);
        #1;
        checks++;
        if (ex !== it.exec) begin
          errors++;
          $display("FAIL %s exec_en got %b exp %b", it.tag, ex, it.exec);
        end
        checks++;
        if ({n_o, z_o, c_o, v_o, e_o} !== it.post) begin
          errors++;
          $display("FAIL %s nzcve got %b exp %b", it.tag,
                   {n_o, z_o, c_o, v_o, e_o}, it.post);
        end
      end
    end
  end

  // sets the reference flag state through a compare
  task automatic load_flags(string tag, logic n, logic z, logic c, logic v);
    step(tag, 4'hE, 2'b10, 1'b0, n ? 32'h8000_0000 : (z ? 32'h0 : 32'h1), c, v);
  endtask

  initial begin
    e_wr_i = 1'b1; e_val_i = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if ({n_o, z_o, c_o, v_o, e_o} !== 5'b0) begin
      errors++;
      $display("FAIL R1 reset state got %b exp 00000", {n_o, z_o, c_o, v_o, e_o});
    end
    @(negedge clk);
    rst = 1'b0; e_wr_i = 1'b0; e_val_i = 1'b0;

    step("R2_R3 arith zero carry", 4'hE, 2'b00, 1, 32'h0, 1, 0);
    step("R2_R3 arith neg ovf",    4'hE, 2'b00, 1, 32'h8000_0000, 0, 1);
    step("R4 logic keeps V",       4'hE, 2'b01, 1, 32'h5, 1, 0);
    step("R5 arith no setf",       4'hE, 2'b00, 0, 32'h0, 0, 0);
    step("R5 logic no setf",       4'hE, 2'b01, 0, 32'hFFFF_FFFF, 0, 0);
    step("R6 compare no setf",     4'hE, 2'b10, 0, 32'h0, 1, 0);
    step("R11 none class",         4'hE, 2'b11, 1, 32'h8000_0000, 0, 1);

    // R8: Z=0, EQ fails with set-flags
    load_flags("R8 setup", 0, 0, 1, 1);
    step("R8 failed cond setf",    4'h0, 2'b00, 1, 32'h0, 0, 0);
    step("R8 failed compare",      4'h0, 2'b10, 0, 32'h0, 0, 0);

    // R9: EQ passes on old Z=1, own update clears Z, next EQ fails
    load_flags("R9 setup", 0, 1, 0, 0);
    step("R9 gate uses old flags", 4'h0, 2'b10, 0, 32'h1, 0, 0);
    step("R9 update seen next",    4'h0, 2'b00, 1, 32'h0, 0, 0);

    // R10
    step("R10 E write",            4'hE, 2'b10, 1, 32'h0, 1, 1, 1, 1);
    step("R10 flags keep E",       4'hE, 2'b00, 1, 32'h7, 0, 0);
    step("R10 value no strobe",    4'hE, 2'b00, 0, 32'h7, 0, 0, 0, 0);
    step("R10 E clear",            4'hF, 2'b11, 0, 32'h0, 0, 0, 1, 0);

    // R7 sweep
    for (int s = 0; s < 16; s++) begin
      if (s[3] && s[2]) continue;
      load_flags("R7 setup", s[3], s[2], s[1], s[0]);
      for (int cc = 0; cc < 16; cc++)
        step("R7 cond table", 4'(cc), 2'b00, 0, 32'h0, 1, 1);
    end

    step("R2 tail", 4'hE, 2'b01, 1, 32'h4000_0000, 0, 0);
    repeat (3) @(posedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule